// File: doc/BRIEF.md
# Boot Retry Delay Selector

This block sits in front of a network boot engine and decides how long to hold off before a boot attempt goes out, so that a machine that keeps rebooting does not flood the network with requests. When a start request is accepted, the block reads a boot-reason vector. That vector arrives with every bit inverted, so the block restores the true value first. A fixed mask then picks a short or a long wait. The wait runs as a two-level countdown: an outer count of steps, and inside each step a full inner count.

At the same accepted start, the block captures the status code that was on the display beforehand. While the wait runs, and after it, the display shows the block's own status code. If the boot engine later reports that the boot failed, the display alternates between the captured code and the block's own code. The alternation runs at a programmable period until reset or the next accepted start. Completion of the wait is signalled by a one-cycle pulse.

Top module: `boot_retry_delay`

## Requirements
- R1: After reset, `delay_done_o` is low and `status_o` equals the parameter OWN_CODE.
- R2: The true reason is `reason_i` XOR all-ones (6'o77 at the default width). When the true reason AND'ed with REASON_MASK (default 6'o62: bits 1, 4 and 5, the power-on, tester and push-button causes) is non-zero, the outer count loads OUTER_SHORT. Otherwise it loads OUTER_LONG, so bits 0 and 2 (programmed and parity boots) alone give the long wait.
- R3: If `start_i` is sampled high at clock edge k while the block is idle, `delay_done_o` is high in the cycle after edge k+(N+1)*(INNER_LOAD+1). N is the outer value loaded by R2.
- R4: `delay_done_o` is high for exactly one cycle per completed wait.
- R5: A `start_i` that arrives while a wait is running is ignored. The finishing time does not change, and neither does the captured code.
- R6: Whenever the block is not alternating, `status_o` equals OWN_CODE, including during the wait and after a wait that is not followed by a failure.
- R7: `prev_code_i` is captured at the edge where a start is accepted. That captured value is the code shown by the alternation.
- R8: If `boot_fail_i` is sampled high at edge f after a completed wait, `status_o` shows the captured code for the BLINK_PERIOD cycles after edge f. It then switches between OWN_CODE and the captured code every BLINK_PERIOD cycles.
- R9: `boot_fail_i` has no effect before the first completed wait after reset or after a start, and none while a wait is running.
- R10: A start accepted during alternation stops it: `status_o` equals OWN_CODE from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a hold-off wait |
| reason_i | input | REASON_W | Boot-reason bits, each inverted |
| prev_code_i | input | CODE_W | Status code shown before this attempt |
| boot_fail_i | input | 1 | Boot engine reports a failed attempt |
| delay_done_o | output | 1 | One-cycle pulse when the wait ends |
| status_o | output | CODE_W | Code driven to the status display |

## Verification
The assertions assume that `start_i` and `boot_fail_i` are ordinary synchronous levels. They also assume that `prev_code_i` differs from OWN_CODE whenever the alternation pattern is meant to be visible, because the checks tell the two display sources apart by value. The bench changes every input only on falling edges and holds each request for a single sampling edge. It always picks previous codes distinct from the block's own code. Its ignored-request cases fire while the wait is clearly running or before any wait has completed, which keeps each one unambiguous.

// File: rtl/boot_delay_pkg.sv
package boot_delay_pkg;

   typedef enum logic {
      CD_IDLE = 1'b0,
      CD_RUN  = 1'b1
   } cd_state_t;

   // width needed to hold values 0..maxv, never below one bit
   function automatic int cnt_width(input int maxv);
      int w;
      w = $clog2(maxv + 1);
      return (w < 1) ? 1 : w;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/reason_decode.sv
module reason_decode #(
   parameter int                 REASON_W = 6,
   parameter bit                 INVERTED = 1'b1,
   parameter logic [REASON_W-1:0] MASK    = 6'o62,
   parameter int                 OW       = 14,
   parameter int                 SHORT_N  = 256,
   parameter int                 LONG_N   = 8192
) (
   input  logic [REASON_W-1:0] raw_i,
   output logic                quick_o,
   output logic [OW-1:0]       outer_init_o
);
   localparam logic [REASON_W-1:0] ALL_ONES = {REASON_W{1'b1}};
   localparam logic [OW-1:0] SHORT_V = OW'(SHORT_N);
   localparam logic [OW-1:0] LONG_V  = OW'(LONG_N);

   logic [REASON_W-1:0] true_reason;

   generate
      if (INVERTED) begin : g_inv
         assign true_reason = raw_i ^ ALL_ONES;
      end else begin : g_direct
         assign true_reason = raw_i;
      end
   endgenerate

   assign quick_o      = |(true_reason & MASK);
   assign outer_init_o = quick_o ? SHORT_V : LONG_V;

endmodule

// File: rtl/nested_countdown.sv
module nested_countdown
   import boot_delay_pkg::*;
#(
   parameter int OW         = 14,
   parameter int INNER_LOAD = 24576
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [OW-1:0] outer_init_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [OW-1:0] outer_o
);
   localparam int          IW      = cnt_width(INNER_LOAD);
   localparam logic [IW-1:0] INNER_V = IW'(INNER_LOAD);

   cd_state_t     state;
   logic [OW-1:0] outer_q;
   logic [IW-1:0] inner_q;
   logic          inner_last;
   logic          outer_last;

   assign inner_last = (inner_q == '0);
   assign outer_last = (outer_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CD_IDLE;
         outer_q <= '0;
         inner_q <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            CD_IDLE: begin
               if (load_i) begin
                  state   <= CD_RUN;
                  outer_q <= outer_init_i;
                  inner_q <= INNER_V;
               end
            end
            CD_RUN: begin
               if (!inner_last) begin
                  inner_q <= inner_q - 1'b1;
               end else if (!outer_last) begin
                  outer_q <= outer_q - 1'b1;
                  inner_q <= INNER_V;
               end else begin
                  state  <= CD_IDLE;
                  done_o <= 1'b1;
               end
            end
            default: state <= CD_IDLE;
         endcase
      end
   end

   assign busy_o  = (state == CD_RUN);
   assign outer_o = outer_q;

endmodule

// File: rtl/status_blinker.sv
module status_blinker
   import boot_delay_pkg::*;
#(
   parameter int              CODE_W       = 12,
   parameter logic [CODE_W-1:0] OWN_CODE   = 12'd758,
   parameter int              BLINK_PERIOD = 12500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              done_i,
   input  logic              fail_i,
   output logic [CODE_W-1:0] status_o,
   output logic              blinking_o,
   output logic [CODE_W-1:0] saved_o
);
   logic              armed_q;
   logic              blink_q;
   logic              phase_q;
   logic              tick;
   logic [CODE_W-1:0] saved_q;
   logic              begin_blink;

   assign begin_blink = fail_i && armed_q && !blink_q;

   generate
      if (BLINK_PERIOD == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int            PW    = cnt_width(BLINK_PERIOD - 1);
         localparam logic [PW-1:0] LAST  = PW'(BLINK_PERIOD - 1);
         logic [PW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (capture_i || begin_blink || !blink_q) begin
               div_q <= '0;
            end else if (div_q == LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = (div_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         blink_q <= 1'b0;
         phase_q <= 1'b0;
         saved_q <= '0;
      end else if (capture_i) begin
         saved_q <= code_i;
         armed_q <= 1'b0;
         blink_q <= 1'b0;
         phase_q <= 1'b0;
      end else if (done_i) begin
         armed_q <= 1'b1;
      end else if (begin_blink) begin
         blink_q <= 1'b1;
         phase_q <= 1'b1;
      end else if (blink_q && tick) begin
         phase_q <= ~phase_q;
      end
   end

   assign status_o   = (blink_q && phase_q) ? saved_q : OWN_CODE;
   assign blinking_o = blink_q;
   assign saved_o    = saved_q;

endmodule

// File: rtl/boot_retry_delay.sv
module boot_retry_delay
   import boot_delay_pkg::*;
#(
   parameter int                  REASON_W        = 6,
   parameter int                  CODE_W          = 12,
   parameter bit                  INVERTED_REASON = 1'b1,
   parameter logic [REASON_W-1:0] REASON_MASK     = 6'o62,
   parameter int                  OUTER_SHORT     = 256,
   parameter int                  OUTER_LONG      = 8192,
   parameter int                  INNER_LOAD      = 24576,
   parameter int                  BLINK_PERIOD    = 12500000,
   parameter logic [CODE_W-1:0]   OWN_CODE        = 12'd758
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [REASON_W-1:0] reason_i,
   input  logic [CODE_W-1:0]   prev_code_i,
   input  logic                boot_fail_i,
   output logic                delay_done_o,
   output logic [CODE_W-1:0]   status_o
);
   localparam int OUTER_MAX = max2(OUTER_SHORT, OUTER_LONG);
   localparam int OW        = cnt_width(OUTER_MAX);

   generate
      if (REASON_W < 1) begin : g_bad_reason_w
         $error("REASON_W must be at least 1");
      end
      if (CODE_W < 1) begin : g_bad_code_w
         $error("CODE_W must be at least 1");
      end
      if (OUTER_SHORT < 0 || OUTER_LONG < 0 || INNER_LOAD < 0) begin : g_bad_counts
         $error("delay counts must not be negative");
      end
      if (BLINK_PERIOD < 1) begin : g_bad_blink
         $error("BLINK_PERIOD must be at least 1");
      end
   endgenerate

   logic          cd_busy;
   logic          accept;
   logic          quick_sel;
   logic [OW-1:0] outer_init;
   logic [OW-1:0] outer_cnt;
   logic          blinking;
   logic [CODE_W-1:0] saved_code;

   assign accept = start_i && !cd_busy;

   reason_decode #(
      .REASON_W (REASON_W),
      .INVERTED (INVERTED_REASON),
      .MASK     (REASON_MASK),
      .OW       (OW),
      .SHORT_N  (OUTER_SHORT),
      .LONG_N   (OUTER_LONG)
   ) i_decode (
      .raw_i        (reason_i),
      .quick_o      (quick_sel),
      .outer_init_o (outer_init)
   );

   nested_countdown #(
      .OW         (OW),
      .INNER_LOAD (INNER_LOAD)
   ) i_countdown (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (accept),
      .outer_init_i (outer_init),
      .busy_o       (cd_busy),
      .done_o       (delay_done_o),
      .outer_o      (outer_cnt)
   );

   status_blinker #(
      .CODE_W       (CODE_W),
      .OWN_CODE     (OWN_CODE),
      .BLINK_PERIOD (BLINK_PERIOD)
   ) i_blinker (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_i  (accept),
      .code_i     (prev_code_i),
      .done_i     (delay_done_o),
      .fail_i     (boot_fail_i && !cd_busy),
      .status_o   (status_o),
      .blinking_o (blinking),
      .saved_o    (saved_code)
   );

endmodule

// File: rtl/boot_retry_delay_chk.sv
module boot_retry_delay_chk #(
   parameter int              CODE_W    = 12,
   parameter int              OW        = 14,
   parameter int              OUTER_MAX = 8192,
   parameter logic [CODE_W-1:0] OWN_CODE = 12'd758
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              delay_done_o,
   input logic [CODE_W-1:0] status_o,
   input logic              busy,
   input logic              blinking,
   input logic [CODE_W-1:0] saved_code,
   input logic [OW-1:0]     outer_cnt
);
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      delay_done_o |=> !delay_done_o); // R4
   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      delay_done_o |-> (!busy && $past(busy))); // R3
   AST_OUTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      outer_cnt <= OW'(OUTER_MAX)); // R3
   AST_BUSY_START_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> $stable(saved_code)); // R5
   AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> (busy || delay_done_o)); // R5
   AST_STEADY_OWN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !blinking |-> (status_o == OWN_CODE)); // R6
   AST_BLINK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      blinking |-> (status_o == OWN_CODE || status_o == saved_code)); // R8
   AST_NO_BLINK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !blinking); // R9
   AST_START_STOPS_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy) |=> !blinking); // R10
endmodule

bind boot_retry_delay boot_retry_delay_chk #(
   .CODE_W    (CODE_W),
   .OW        (OW),
   .OUTER_MAX (OUTER_MAX),
   .OWN_CODE  (OWN_CODE)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .delay_done_o (delay_done_o),
   .status_o     (status_o),
   .busy         (cd_busy),
   .blinking     (blinking),
   .saved_code   (saved_code),
   .outer_cnt    (outer_cnt)
);

// File: tb/test_boot_retry_delay.sv
`timescale 1ns/1ps
module test_boot_retry_delay;
   localparam int          RW    = 6;
   localparam int          CW    = 12;
   localparam int          OS    = 3;
   localparam int          OL    = 9;
   localparam int          IN    = 4;
   localparam int          BP    = 3;
   localparam logic [CW-1:0] OWN = 12'h5A3;
   localparam int          T_SHORT = (OS + 1) * (IN + 1);
   localparam int          T_LONG  = (OL + 1) * (IN + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [RW-1:0] reason_i = '0;
   logic [CW-1:0] prev_code_i = '0;
   logic          boot_fail_i = 1'b0;
   logic          delay_done_o;
   logic [CW-1:0] status_o;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   boot_retry_delay #(
      .REASON_W (RW), .CODE_W (CW), .OUTER_SHORT (OS), .OUTER_LONG (OL),
      .INNER_LOAD (IN), .BLINK_PERIOD (BP), .OWN_CODE (OWN)
   ) i_boot_retry_delay (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .reason_i (reason_i),
      .prev_code_i (prev_code_i), .boot_fail_i (boot_fail_i),
      .delay_done_o (delay_done_o), .status_o (status_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // accept a start with the given true reason; returns start cycle
   task automatic pulse_start(input logic [RW-1:0] true_reason,
                              input logic [CW-1:0] code, output int t0);
      @(negedge clk);
      start_i = 1'b1;
      reason_i = ~true_reason;
      prev_code_i = code;
      @(negedge clk);
      t0 = cyc;
      start_i = 1'b0;
      reason_i = '0;
      prev_code_i = '0;
   endtask

   task automatic wait_done(input int t0, output int lat);
      lat = -1;
      for (int i = 0; i < 2000; i++) begin
         if (delay_done_o) begin
            lat = cyc - t0;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_delay(input string req, input logic [RW-1:0] true_reason,
                            input int exp_lat);
      int t0, lat;
      pulse_start(true_reason, 12'h111, t0);
      check({req, " status during wait"}, status_o, OWN); // R6
      wait_done(t0, lat);
      check({req, " wait length"}, lat, exp_lat);
      @(negedge clk);
      check("R4 done drops after one cycle", delay_done_o, 0);
      check("R6 status after success", status_o, OWN);
   endtask

   task automatic fail_pulse();
      @(negedge clk);
      boot_fail_i = 1'b1;
      @(negedge clk);
      boot_fail_i = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 done low in reset", delay_done_o, 0);
      check("R1 status own code in reset", status_o, OWN);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status own code after reset", status_o, OWN);
   endtask

   task automatic t_reasons();
      run_delay("R2 R3 power-on bit1 short", 6'o02, T_SHORT);
      run_delay("R2 tester bit4 short", 6'o20, T_SHORT);
      run_delay("R2 push-button bit5 short", 6'o40, T_SHORT);
      run_delay("R2 programmed+parity bits0,2 long", 6'o05, T_LONG);
      run_delay("R2 R3 no reason long", 6'o00, T_LONG);
      run_delay("R2 bit3 outside mask long", 6'o10, T_LONG);
   endtask

   task automatic t_fail_ignored();
      int t0, lat;
      t_reset();
      fail_pulse();
      repeat (BP) @(negedge clk);
      check("R9 fail before any wait ignored", status_o, OWN);
      pulse_start(6'o00, 12'h222, t0);
      repeat (5) @(negedge clk);
      boot_fail_i = 1'b1;
      @(negedge clk);
      boot_fail_i = 1'b0;
      repeat (BP + 1) @(negedge clk);
      check("R9 fail during wait ignored", status_o, OWN);
      wait_done(t0, lat);
      check("R9 wait length unchanged", lat, T_LONG);
      repeat (2 * BP + 2) @(negedge clk);
      check("R9 no blink after ignored fail", status_o, OWN);
   endtask

   task automatic t_start_ignored_and_blink();
      int t0, lat;
      pulse_start(6'o00, 12'h3C7, t0);
      repeat (10) @(negedge clk);
      start_i = 1'b1;
      reason_i = ~6'o02;
      prev_code_i = 12'h0F0;
      @(negedge clk);
      start_i = 1'b0;
      reason_i = '0;
      prev_code_i = '0;
      wait_done(t0, lat);
      check("R5 start during wait keeps length", lat, T_LONG);
      // blink: fail sampled at edge f, checks at negedges after f+k
      fail_pulse();
      check("R7 R8 captured code shown first", status_o, 12'h3C7);
      repeat (BP - 1) @(negedge clk);
      check("R8 captured code held for period", status_o, 12'h3C7);
      @(negedge clk);
      check("R8 own code after period", status_o, OWN);
      repeat (BP - 1) @(negedge clk);
      check("R8 own code held for period", status_o, OWN);
      @(negedge clk);
      check("R5 R8 captured code again, late start ignored", status_o, 12'h3C7);
   endtask

   task automatic t_restart_from_blink();
      int t0, lat;
      pulse_start(6'o40, 12'h444, t0);
      check("R10 start stops blink", status_o, OWN);
      repeat (2 * BP) @(negedge clk);
      check("R10 stays own code", status_o, OWN);
      wait_done(t0, lat);
      check("R10 R3 new short wait length", lat, T_SHORT);
      fail_pulse();
      check("R7 newly captured code shown", status_o, 12'h444);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_reasons();
      t_fail_ignored();
      t_start_ignored_and_blink();
      t_restart_from_blink();
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule